// File: doc/BRIEF.md
# User Reset Sequencer

This block turns a low level on the active-low board reset pin into an ordered reset of the processor and its peripherals. It runs entirely on the slow clock. The pin level passes through a multi-stage synchronizer before any decision uses it. When the user-reset enable input is set and the synchronized pin reads low, the block pulls both internal resets low and stops the processor clock. It also drives the pin low itself through an open-drain pull-down, for a programmed minimum number of cycles.

Release waits for two things: the programmed pull-down time must have run out, and the pin must actually be high again. An outside source that keeps the pin low therefore stretches the reset. The processor clock enable comes back as soon as the synchronized pin shows high. A fixed three-cycle startup window follows. After it, both resets are released together and a cause code marking a user-triggered reset is stored in the status output.

Top module: `usr_rst_seq`

## Requirements
- R1: The pin is sampled through a two-stage synchronizer. If the pin goes low just before clock edge 1, the resets go low at edge 3.
- R2: While the enable input is 0, a low pin leaves every output unchanged: the resets stay high, the pull-down stays off, the clock enable stays high and the cause code keeps its value.
- R3: On entry, the processor reset and the peripheral reset both go low and the processor clock enable goes low.
- R4: The pull-down output is 1 for exactly 2^(len+1) cycles, where len is the 4-bit length input. It starts on the entry cycle.
- R5: The internal resets stay low until the pin's real rise has been seen through the synchronizer, even when the rise comes long after the pull-down time has ended.
- R6: The clock enable returns to 1 on the cycle after the synchronized pin is first seen high. This is three cycles before the resets are released.
- R7: After the clock enable returns, the resets stay low for three startup cycles. The processor reset and the peripheral reset are then released on the same cycle.
- R8: The cause code is 0 after block reset. It becomes 4 (user reset) on the cycle the processor reset is released, and it holds that value at all other times.
- R9: After block reset, both resets are 1, the pull-down is 0, the clock enable is 1 and the cause code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow clock |
| rst_ni | input | 1 | Asynchronous block reset, active low |
| ext_rst_ni | input | 1 | Level read back from the board reset pin |
| usr_rst_en_i | input | 1 | Allows a low pin to start a user reset |
| rst_len_i | input | 4 | Pull-down length code; hold time is 2^(len+1) cycles |
| pin_pull_o | output | 1 | 1 drives the board reset pin low |
| proc_rst_no | output | 1 | Processor reset, active low |
| periph_rst_no | output | 1 | Peripheral reset, active low |
| proc_clk_en_o | output | 1 | Processor clock enable |
| rst_cause_o | output | 3 | Stored reset cause code |

## Verification
The assertions check on every cycle that a new reset sequence can start only while the enable input is set. They also check that the pull-down is active only while reset and clock gating are in force, and that the clock enable returns only after the pin has read high three cycles earlier. At release they check that the clock enable was already back on the previous cycle, and that the cause code changes only at release and only to 4. The exact cycle counts need the bench scenarios, which sweep the length code and how long the pin is held from outside. These counts are the synchronizer delay, the pull-down length, the stretched reset when the pin is held low from outside, and the startup window.

// File: rtl/usr_rst_pkg.sv
package usr_rst_pkg;

   typedef enum logic [2:0] {
      URS_IDLE      = 3'd0,
      URS_ASSERT    = 3'd1,
      URS_WAIT_RISE = 3'd2,
      URS_STARTUP   = 3'd3,
      URS_DONE      = 3'd4
   } urs_state_e;

endpackage

// File: rtl/usr_rst_sync.sv
module usr_rst_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic async_i,
   output logic sync_o
);

   logic [STAGES-1:0] chain_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[0] <= RESET_VAL;
            else         chain_q[0] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[s] <= RESET_VAL;
            else         chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/usr_rst_timer.sv
module usr_rst_timer #(
   parameter int W = 16
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic         dec_i,
   output logic         zero_o
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     cnt_q <= '0;
      else if (load_i)                 cnt_q <= load_val_i;
      else if (dec_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/usr_rst_seq.sv
module usr_rst_seq
   import usr_rst_pkg::*;
#(
   parameter int SYNC_STAGES    = 2,
   parameter int STARTUP_CYCLES = 3,
   parameter int LEN_W          = 4,
   parameter int CAUSE_W        = 3,
   parameter int CAUSE_USER     = 4
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               ext_rst_ni,
   input  logic               usr_rst_en_i,
   input  logic [LEN_W-1:0]   rst_len_i,
   output logic               pin_pull_o,
   output logic               proc_rst_no,
   output logic               periph_rst_no,
   output logic               proc_clk_en_o,
   output logic [CAUSE_W-1:0] rst_cause_o
);

   localparam int CNT_W = 1 << LEN_W;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("usr_rst_seq: SYNC_STAGES must be at least 2");
   end
   if (STARTUP_CYCLES < 1 || STARTUP_CYCLES > (1 << (CNT_W - 1))) begin : g_bad_startup
      $error("usr_rst_seq: STARTUP_CYCLES out of range for the shared counter");
   end
   if (CAUSE_USER >= (1 << CAUSE_W)) begin : g_bad_cause
      $error("usr_rst_seq: CAUSE_USER does not fit CAUSE_W");
   end

   logic             pin_s;
   logic             tmr_load;
   logic             tmr_dec;
   logic             tmr_zero;
   logic [CNT_W-1:0] tmr_val;
   logic [CNT_W:0]   hold_len;
   urs_state_e       state_q, state_d;
   logic [CAUSE_W-1:0] cause_q;
   logic             cause_load;

   usr_rst_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (ext_rst_ni),
      .sync_o  (pin_s)
   );

   usr_rst_timer #(
      .W (CNT_W)
   ) u_timer (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .dec_i      (tmr_dec),
      .zero_o     (tmr_zero)
   );

   assign hold_len = (CNT_W + 1)'(2) << rst_len_i;

   always_comb begin
      state_d    = state_q;
      tmr_load   = 1'b0;
      tmr_dec    = 1'b0;
      tmr_val    = CNT_W'(hold_len - 1'b1);
      cause_load = 1'b0;
      unique case (state_q)
         URS_IDLE: begin
            if (usr_rst_en_i && !pin_s) begin
               tmr_load = 1'b1;
               state_d  = URS_ASSERT;
            end
         end
         URS_ASSERT: begin
            if (tmr_zero) state_d = URS_WAIT_RISE;
            else          tmr_dec = 1'b1;
         end
         URS_WAIT_RISE: begin
            if (pin_s) begin
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(STARTUP_CYCLES - 1);
               state_d  = URS_STARTUP;
            end
         end
         URS_STARTUP: begin
            if (tmr_zero) begin
               cause_load = 1'b1;
               state_d    = URS_DONE;
            end else begin
               tmr_dec = 1'b1;
            end
         end
         URS_DONE: state_d = URS_IDLE;
         default:  state_d = URS_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= URS_IDLE;
         cause_q <= '0;
      end else begin
         state_q <= state_d;
         if (cause_load) cause_q <= CAUSE_W'(CAUSE_USER);
      end
   end

   assign pin_pull_o    = (state_q == URS_ASSERT);
   assign proc_rst_no   = !(state_q inside {URS_ASSERT, URS_WAIT_RISE, URS_STARTUP});
   assign periph_rst_no = !(state_q inside {URS_ASSERT, URS_WAIT_RISE, URS_STARTUP});
   assign proc_clk_en_o = !(state_q inside {URS_ASSERT, URS_WAIT_RISE});
   assign rst_cause_o   = cause_q;

endmodule

// File: rtl/usr_rst_seq_chk.sv
module usr_rst_seq_chk #(
   parameter int CAUSE_W    = 3,
   parameter int CAUSE_USER = 4
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               ext_rst_ni,
   input logic               usr_rst_en_i,
   input logic               pin_pull_o,
   input logic               proc_rst_no,
   input logic               periph_rst_no,
   input logic               proc_clk_en_o,
   input logic [CAUSE_W-1:0] rst_cause_o
);

   // R2
   entry_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(proc_rst_no) |-> $past(usr_rst_en_i));

   // R4
   pull_only_in_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pin_pull_o |-> (!proc_rst_no && !periph_rst_no && !proc_clk_en_o));

   // R5
   clk_back_after_pin_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(proc_clk_en_o) |-> $past(ext_rst_ni, 3));

   // R6
   clk_before_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(proc_rst_no) |-> $past(proc_clk_en_o));

   // R8
   cause_at_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(proc_rst_no) |-> (rst_cause_o == CAUSE_W'(CAUSE_USER)));

   // R8
   cause_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$rose(proc_rst_no) |-> $stable(rst_cause_o));

endmodule

bind usr_rst_seq usr_rst_seq_chk #(
   .CAUSE_W    (CAUSE_W),
   .CAUSE_USER (CAUSE_USER)
) chk_i (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .ext_rst_ni    (ext_rst_ni),
   .usr_rst_en_i  (usr_rst_en_i),
   .pin_pull_o    (pin_pull_o),
   .proc_rst_no   (proc_rst_no),
   .periph_rst_no (periph_rst_no),
   .proc_clk_en_o (proc_clk_en_o),
   .rst_cause_o   (rst_cause_o)
);

// File: tb/usr_rst_seq_tb_top.sv
module usr_rst_seq_tb_top;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       en;
   logic       ext_drv_n;
   logic [3:0] len;
   logic       pin_pull;
   logic       proc_rst_n;
   logic       periph_rst_n;
   logic       clk_en;
   logic [2:0] cause;
   logic       pin_level;

   int checks = 0;
   int errors = 0;
   bit done_flag = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // open-drain pin: low if either the board or the block pulls it
   assign pin_level = ext_drv_n & ~pin_pull;

   usr_rst_seq dut_i (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .ext_rst_ni    (pin_level),
      .usr_rst_en_i  (en),
      .rst_len_i     (len),
      .pin_pull_o    (pin_pull),
      .proc_rst_no   (proc_rst_n),
      .periph_rst_no (periph_rst_n),
      .proc_clk_en_o (clk_en),
      .rst_cause_o   (cause)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Hold the pin low from outside for 'hold' edges and compare every cycle.
   task automatic run_case(input int lv, input int hold, input bit en_v);
      int L     = 2 << lv;
      int P     = (hold + 1 > 4 + L) ? hold + 1 : 4 + L;
      int last  = en_v ? P + 7 : hold + 4;
      int c0    = int'(cause);
      int first_low = 0;
      bit b_rst = 0, b_per = 0, b_drv = 0, b_clk = 0, b_cau = 0;
      int a_rst = 0, e_rst = 0, a_per = 0, e_per = 0, a_drv = 0, e_drv = 0;
      int a_clk = 0, e_clk = 0, a_cau = 0, e_cau = 0;
      @(negedge clk);
      len = 4'(lv); en = en_v; ext_drv_n = 1'b0;
      for (int k = 1; k <= last; k++) begin
         int x_rst, x_drv, x_clk, x_cau;
         @(negedge clk);
         if (en_v) begin
            x_rst = (k >= 3 && k <= P + 4) ? 0 : 1;
            x_drv = (k >= 3 && k <= 2 + L) ? 1 : 0;
            x_clk = (k >= 3 && k <= P + 1) ? 0 : 1;
            x_cau = (k >= P + 5) ? 4 : c0;
         end else begin
            x_rst = 1; x_drv = 0; x_clk = 1; x_cau = c0;
         end
         if (first_low == 0 && !proc_rst_n) first_low = k;
         if (!b_rst && int'(proc_rst_n) != x_rst)   begin b_rst = 1; a_rst = int'(proc_rst_n);   e_rst = x_rst; end
         if (!b_per && int'(periph_rst_n) != x_rst) begin b_per = 1; a_per = int'(periph_rst_n); e_per = x_rst; end
         if (!b_drv && int'(pin_pull) != x_drv)     begin b_drv = 1; a_drv = int'(pin_pull);     e_drv = x_drv; end
         if (!b_clk && int'(clk_en) != x_clk)       begin b_clk = 1; a_clk = int'(clk_en);       e_clk = x_clk; end
         if (!b_cau && int'(cause) != x_cau)        begin b_cau = 1; a_cau = int'(cause);        e_cau = x_cau; end
         if (k == hold) ext_drv_n = 1'b1;
      end
      if (en_v) begin
         check(first_low == 3, "R1", "entry edge", first_low, 3);
         check(!b_rst, "R5", "proc reset trace", a_rst, e_rst);
         check(!b_per, "R7", "periph reset trace", a_per, e_per);
         check(!b_drv, "R4", "pin pull trace", a_drv, e_drv);
         check(!b_clk, "R6", "clock enable trace", a_clk, e_clk);
         check(!b_cau, "R8", "cause trace", a_cau, e_cau);
         check(!b_rst && !b_clk, "R3", "entry asserts resets and gates clock", a_rst, e_rst);
      end else begin
         check(!b_rst && !b_per, "R2", "resets while disabled", a_rst, e_rst);
         check(!b_drv && !b_clk, "R2", "pull and clock while disabled", a_drv, e_drv);
         check(!b_cau, "R2", "cause while disabled", a_cau, e_cau);
      end
      repeat (3) @(negedge clk);
   endtask

   initial begin
      rst_n = 1'b0; en = 1'b0; ext_drv_n = 1'b1; len = 4'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: block reset state
      check(proc_rst_n && periph_rst_n, "R9", "resets after block reset", int'(proc_rst_n), 1);
      check(!pin_pull && clk_en, "R9", "pull and clock after block reset", int'(pin_pull), 0);
      check(cause == 3'd0, "R9", "cause after block reset", int'(cause), 0);
      run_case(1, 6, 1'b0);
      // R8: cause still 0 before any user reset
      check(cause == 3'd0, "R8", "cause before first user reset", int'(cause), 0);
      for (int lv = 0; lv <= 3; lv++) begin
         for (int hold = 1; hold <= (2 << lv) + 6; hold++) begin
            run_case(lv, hold, 1'b1);
         end
      end
      run_case(0, 40, 1'b1);
      run_case(2, 5, 1'b0);
      check(cause == 3'd4, "R8", "cause held after disabled low", int'(cause), 4);
      done_flag = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done_flag) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule